// File: doc/BRIEF.md
# SCSI Host Register Block

This block is the register file that a CPU uses to run a SCSI initiator. The CPU side is a 4-bit offset, separate read and write strobes and a byte of write data. Read data is combinational and is valid in the same cycle as the read strobe. On the bus side, bits written by the CPU drive the control lines. Live phase and status lines come back to the CPU as read-only snapshot bytes.

The block holds a command byte for the control lines, a mode byte and an expected-phase byte. A phase-match flag compares the expected phase with the live MSG, C/D and I/O lines. The block also runs a small pseudo-DMA handshake. A start write raises the request flag DRQ. A CPU touch of a data port raises the acknowledge flag DACK. When the byte mover finishes with the byte, it pulses `ack_consumed` and the handshake ends.

Top module: `scsi_hostreg`

## Requirements
- R1: After reset, every stored byte reads as zero, all drive outputs and `data_out` are low, and `drq` and `dack` are low.
- R2: A write to offset 1 sets the drive outputs on the next clock edge from the written byte: bit 7 → `drv_rst`, bit 4 → `drv_ack`, bit 3 → `drv_bsy`, bit 2 → `drv_sel`, bit 1 → `drv_atn`, bit 0 → `drv_data_en`. A write to offset 0 sets `data_out`.
- R3: A read of offset 1 returns the stored byte, with bit 6 forced to 1 while bit 0 of the mode byte (offset 2) is set.
- R4: A read of offset 4 returns {RST, BSY, REQ, MSG, C/D, I/O, SEL, parity} from bit 7 down to bit 0. RST, BSY and SEL each read as the OR of the host drive bit and the live bus line.
- R5: A read of offset 5 returns the host ACK drive in bit 0, the host ATN drive in bit 1, the phase-match flag in bit 3 and DRQ in bit 6; all other bits are zero. Phase match is set when bits 2:0 of offset 3 equal {MSG, C/D, I/O}.
- R6: A write to offset 5, 6 or 7 sets `drq` on the next edge.
- R7: While `drq` is high, a read of offset 6 or a write to offset 0 sets `dack` on the next edge. While `drq` is low, the same access leaves `dack` low.
- R8: Bit 1 of the mode byte drives `dma_mode`. Writing the mode byte with bit 1 clear forces both `drq` and `dack` low, and this overrides every other source.
- R9: A one-cycle `ack_consumed` pulse clears both `drq` and `dack`.
- R10: Reads of offsets 0 and 6 return `bus_data_in`. A read of offset 7 returns zero.
- R11: A read of offset 2, 3 or 8 to 15 returns the last byte written there. No cycle without a write changes any stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 4 | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| bus_data_in | input | 8 | Live bus data byte |
| bus_rst | input | 1 | Live RST line |
| bus_bsy | input | 1 | Live BSY line from target |
| bus_req | input | 1 | Live REQ line |
| bus_msg | input | 1 | Live MSG line |
| bus_cd | input | 1 | Live C/D line |
| bus_io | input | 1 | Live I/O line |
| bus_sel | input | 1 | Live SEL line |
| bus_dbp | input | 1 | Live data parity line |
| ack_consumed | input | 1 | Byte mover finished the handshake |
| drv_rst | output | 1 | Drive RST |
| drv_ack | output | 1 | Drive ACK |
| drv_bsy | output | 1 | Drive BSY |
| drv_sel | output | 1 | Drive SEL |
| drv_atn | output | 1 | Drive ATN |
| drv_data_en | output | 1 | Enable output data onto bus |
| data_out | output | 8 | Output data latch |
| dma_mode | output | 1 | Pseudo-DMA mode enabled |
| drq | output | 1 | DMA request |
| dack | output | 1 | DMA acknowledge |

## Verification
The bench builds the block with its default 4-bit offset width. That gives all sixteen offsets, so the undefined offsets 8 to 15 are reached as well as the live snapshot bytes. The stimulus table covers the stored bytes and the arbitration overlay. It sets the overlay, checks it, then clears it and checks again.

Directed steps cover the following:
- Phase match and mismatch, with bus levels picked so that each OR term of the status byte is seen on its own.
- The full DRQ/DACK lifecycle, including a data touch while DRQ is low.
- The mode write that forces DRQ and DACK low.

// File: rtl/scsi_hostreg_pkg.sv
package scsi_hostreg_pkg;
    localparam int ADDR_W = 4;
    localparam int BYTE_W = 8;
    localparam int NUM_REGS = 1 << ADDR_W;

    localparam logic [ADDR_W-1:0] OFF_DATA     = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_CMD      = 4'h1;
    localparam logic [ADDR_W-1:0] OFF_MODE     = 4'h2;
    localparam logic [ADDR_W-1:0] OFF_PHASE    = 4'h3;
    localparam logic [ADDR_W-1:0] OFF_STAT     = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_BSTAT    = 4'h5;
    localparam logic [ADDR_W-1:0] OFF_INDATA   = 4'h6;
    localparam logic [ADDR_W-1:0] OFF_CLRSTAT  = 4'h7;

    typedef logic [NUM_REGS-1:0][BYTE_W-1:0] regbank_t;
endpackage

// File: rtl/scsi_hr_regs.sv
module scsi_hr_regs
    import scsi_hostreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output regbank_t          bank_q
);
    typedef struct packed {
        regbank_t bank;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.bank[addr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_q = st_q.bank;

    // R11: stored bytes change only on a write
    assert_hold_without_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank_q));
endmodule

// File: rtl/scsi_hr_dma.sv
module scsi_hr_dma (
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic data_touch,
    input  logic mode_off_wr,
    input  logic ack_consumed,
    output logic drq,
    output logic dack
);
    typedef struct packed {
        logic drq;
        logic dack;
    } hs_t;

    hs_t hs_d, hs_q;

    always_comb begin
        hs_d = hs_q;
        if (mode_off_wr || ack_consumed) begin
            hs_d.drq  = 1'b0;
            hs_d.dack = 1'b0;
        end else begin
            if (start_wr) begin
                hs_d.drq = 1'b1;
            end
            if (hs_q.drq && data_touch) begin
                hs_d.dack = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= '0;
        end else begin
            hs_q <= hs_d;
        end
    end

    assign drq  = hs_q.drq;
    assign dack = hs_q.dack;

    assert_dack_needs_drq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dack) |-> $past(drq));
    assert_dack_within_drq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dack |-> drq);
    assert_start_sets_drq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr && !mode_off_wr && !ack_consumed |=> drq);
    assert_drq_fall_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drq) |-> ($past(ack_consumed) || $past(mode_off_wr)));
    assert_mode_off_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_off_wr |=> (!drq && !dack));
endmodule

// File: rtl/scsi_hr_readmux.sv
module scsi_hr_readmux
    import scsi_hostreg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  regbank_t          bank_q,
    input  logic [BYTE_W-1:0] bus_data_in,
    input  logic              bus_rst,
    input  logic              bus_bsy,
    input  logic              bus_req,
    input  logic              bus_msg,
    input  logic              bus_cd,
    input  logic              bus_io,
    input  logic              bus_sel,
    input  logic              bus_dbp,
    input  logic              drq,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] cmd_b, mode_b, phase_b, stat_b, bstat_b;
    logic              phase_hit;

    always_comb begin
        cmd_b     = bank_q[OFF_CMD];
        mode_b    = bank_q[OFF_MODE];
        phase_b   = bank_q[OFF_PHASE];
        phase_hit = (phase_b[2:0] == {bus_msg, bus_cd, bus_io});
        stat_b    = {cmd_b[7] | bus_rst, cmd_b[3] | bus_bsy, bus_req, bus_msg,
                     bus_cd, bus_io, cmd_b[2] | bus_sel, bus_dbp};
        bstat_b   = {1'b0, drq, 2'b00, phase_hit, 1'b0, cmd_b[1], cmd_b[4]};
        unique case (addr)
            OFF_DATA, OFF_INDATA: rdata = bus_data_in;
            OFF_CMD:              rdata = cmd_b | {1'b0, mode_b[0], 6'b0};
            OFF_STAT:             rdata = stat_b;
            OFF_BSTAT:            rdata = bstat_b;
            OFF_CLRSTAT:          rdata = '0;
            default:              rdata = bank_q[addr];
        endcase
    end
endmodule

// File: rtl/scsi_hostreg.sv
module scsi_hostreg
    import scsi_hostreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  addr,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic [7:0]  bus_data_in,
    input  logic        bus_rst,
    input  logic        bus_bsy,
    input  logic        bus_req,
    input  logic        bus_msg,
    input  logic        bus_cd,
    input  logic        bus_io,
    input  logic        bus_sel,
    input  logic        bus_dbp,
    input  logic        ack_consumed,
    output logic        drv_rst,
    output logic        drv_ack,
    output logic        drv_bsy,
    output logic        drv_sel,
    output logic        drv_atn,
    output logic        drv_data_en,
    output logic [7:0]  data_out,
    output logic        dma_mode,
    output logic        drq,
    output logic        dack
);
    regbank_t bank_q;
    logic     start_wr, data_touch, mode_off_wr;

    scsi_hr_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .bank_q (bank_q)
    );

    always_comb begin
        start_wr    = wr_en && (addr == OFF_BSTAT || addr == OFF_INDATA || addr == OFF_CLRSTAT);
        data_touch  = (rd_en && addr == OFF_INDATA) || (wr_en && addr == OFF_DATA);
        mode_off_wr = wr_en && (addr == OFF_MODE) && !wdata[1];
    end

    scsi_hr_dma u_dma (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_wr     (start_wr),
        .data_touch   (data_touch),
        .mode_off_wr  (mode_off_wr),
        .ack_consumed (ack_consumed),
        .drq          (drq),
        .dack         (dack)
    );

    scsi_hr_readmux u_rmux (
        .addr        (addr),
        .bank_q      (bank_q),
        .bus_data_in (bus_data_in),
        .bus_rst     (bus_rst),
        .bus_bsy     (bus_bsy),
        .bus_req     (bus_req),
        .bus_msg     (bus_msg),
        .bus_cd      (bus_cd),
        .bus_io      (bus_io),
        .bus_sel     (bus_sel),
        .bus_dbp     (bus_dbp),
        .drq         (drq),
        .rdata       (rdata)
    );

    assign drv_rst     = bank_q[OFF_CMD][7];
    assign drv_ack     = bank_q[OFF_CMD][4];
    assign drv_bsy     = bank_q[OFF_CMD][3];
    assign drv_sel     = bank_q[OFF_CMD][2];
    assign drv_atn     = bank_q[OFF_CMD][1];
    assign drv_data_en = bank_q[OFF_CMD][0];
    assign data_out    = bank_q[OFF_DATA];
    assign dma_mode    = bank_q[OFF_MODE][1];

    assert_cmd_drives_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == OFF_CMD |=> drv_sel == $past(wdata[2]));
    assert_cmd_drives_rst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == OFF_CMD |=> drv_rst == $past(wdata[7]));
    assert_data_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == OFF_DATA |=> data_out == $past(wdata));
    assert_mode_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == OFF_MODE |=> dma_mode == $past(wdata[1]));
endmodule

// File: tb/scsi_hostreg_tb.sv
module scsi_hostreg_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;
    // {offset, write byte, expected readback}
    localparam logic [19:0] VEC [NVEC] = '{
        {4'h2, 8'h04, 8'h04},
        {4'h1, 8'h0A, 8'h0A},
        {4'h2, 8'h01, 8'h01},
        {4'h1, 8'h0A, 8'h4A},
        {4'h2, 8'h00, 8'h00},
        {4'h3, 8'h06, 8'h06},
        {4'h8, 8'hA5, 8'hA5},
        {4'hF, 8'h5A, 8'h5A},
        {4'hC, 8'h3C, 8'h3C}
    };

    logic clk = 0, rst_n = 0;
    logic [3:0] addr = 0;
    logic rd_en = 0, wr_en = 0, ack_consumed = 0;
    logic [7:0] wdata = 0, rdata, bus_data_in = 0, data_out;
    logic bus_rst = 0, bus_bsy = 0, bus_req = 0, bus_msg = 0, bus_cd = 0, bus_io = 0;
    logic bus_sel = 0, bus_dbp = 0;
    logic drv_rst, drv_ack, drv_bsy, drv_sel, drv_atn, drv_data_en, dma_mode, drq, dack;
    int errors = 0, checks = 0;
    logic done = 0;
    logic [7:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    scsi_hostreg u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic consume();
        @(negedge clk); ack_consumed = 1;
        @(negedge clk); ack_consumed = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(4'h2, rv); chk("R1 mode", rv, 8'h00);
        rd(4'h9, rv); chk("R1 offset9", rv, 8'h00);
        chk("R1 drives", {drv_rst, drv_ack, drv_bsy, drv_sel, drv_atn, drv_data_en, data_out}, 14'h0);
        chk("R1 dma", {dma_mode, drq, dack}, 3'b000);

        // table: R3 R11
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][19:16], VEC[i][15:8]);
            rd(VEC[i][19:16], rv);
            chk("R3 R11 table", rv, VEC[i][7:0]);
        end

        // R2 drive mapping
        wr(4'h1, 8'h97);
        chk("R2 drives", {drv_rst, drv_ack, drv_bsy, drv_sel, drv_atn, drv_data_en}, 6'b110111);
        wr(4'h0, 8'hC3);
        chk("R2 data_out", data_out, 8'hC3);

        // R4 status snapshot
        wr(4'h1, 8'h00);
        bus_msg = 1; bus_io = 1; bus_req = 1; bus_dbp = 1;
        rd(4'h4, rv); chk("R4 bus only", rv, 8'h35);
        wr(4'h1, 8'h08); bus_sel = 1;
        rd(4'h4, rv); chk("R4 host bsy bus sel", rv, 8'h77);
        bus_sel = 0; bus_rst = 1; wr(4'h1, 8'h04);
        rd(4'h4, rv); chk("R4 bus rst host sel", rv, 8'hB7);
        bus_rst = 0;

        // R5 phase match
        wr(4'h3, 8'h05); wr(4'h1, 8'h12);
        rd(4'h5, rv); chk("R5 match", rv, 8'h0B);
        wr(4'h3, 8'h04);
        rd(4'h5, rv); chk("R5 mismatch", rv, 8'h03);

        // R7 touch with DRQ low has no effect
        wr(4'h2, 8'h02);
        chk("R8 dma_mode", dma_mode, 1'b1);
        rd(4'h6, rv);
        chk("R7 no drq", {drq, dack}, 2'b00);
        // R6 start send
        wr(4'h5, 8'h00);
        chk("R6 start5", {drq, dack}, 2'b10);
        rd(4'h5, rv); chk("R5 drq bit", rv, 8'h43);
        bus_data_in = 8'h9E;
        rd(4'h6, rv); chk("R10 indata", rv, 8'h9E);
        chk("R7 read6 dack", {drq, dack}, 2'b11);
        // R9
        consume();
        chk("R9 consumed", {drq, dack}, 2'b00);
        wr(4'h6, 8'h00);
        chk("R6 start6", drq, 1'b1);
        wr(4'h0, 8'h11);
        chk("R7 write0 dack", dack, 1'b1);
        // R8 mode off
        wr(4'h2, 8'h00);
        chk("R8 forced low", {dma_mode, drq, dack}, 3'b000);
        wr(4'h7, 8'h00);
        chk("R6 start7", drq, 1'b1);
        // R10
        bus_data_in = 8'h6D;
        rd(4'h0, rv); chk("R10 current data", rv, 8'h6D);
        rd(4'h7, rv); chk("R10 offset7", rv, 8'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule